// File: doc/BRIEF.md
# Shared-Address Serial Sample Buffer

This block connects a 32-bit register bus to the serializer of a synchronous serial port. It holds one transmit queue and one receive queue, each with a parameterised depth (16 by default). Both queues sit behind a single bus address, and the direction of the access selects the queue. A bus write appends one sample to the transmit queue. A bus read removes one sample from the receive queue. Every access moves exactly one entry, and each entry is one 32-bit sample word.

Samples are right-justified. The sample width is set by an extended-size bit and a 4-bit size code. On the transmit side, word bits at or above that width are hidden from the serializer. On the receive side, the bits above the width are cleared before the sample is stored.

A small service state machine compares the queue levels with programmable thresholds. It tracks which queue needs attention and drives an interrupt request and a DMA request, each gated by its own enable. A DMA unit-size output tells the DMA controller whether transfers move 1, 2 or 4 bytes.

The service machine has four states:
- **SVC_IDLE**: no queue needs service.
- **SVC_TX**: the transmit queue needs a refill.
- **SVC_RX**: the receive queue needs draining.
- **SVC_BOTH**: both queues need service.

On every clock the machine moves to the state named by the current pair (transmit-need, receive-need):
- **go_idle**: neither queue needs service.
- **go_tx**: only the transmit queue needs service.
- **go_rx**: only the receive queue needs service.
- **go_both**: both queues need service.

Any state can reach any other in one cycle.

Top module: `serial_sample_buffer`

## Requirements
- R1: A bus write with the transmit queue not full stores bus_wdata, and tx_level rises by one after that clock edge. tx_valid is high whenever tx_level is non-zero. A tx_take pulse while tx_valid is high removes the head entry. Samples leave in the order they were written.
- R2: A bus read with the receive queue not empty loads the head sample into bus_rdata one cycle later and removes it. bus_rdata holds its value until the next read. Samples are read in arrival order.
- R3: The sample width is {cfg_ext, cfg_size} + 1 bits, with a minimum of 4, so codes 0 to 3 all give 4 bits and code 31 gives 32 bits. tx_data bits at and above the width are always zero.
- R4: A receive sample is stored with every bit at and above the sample width cleared. The width used is the one in force on the cycle the sample arrives.
- R5: dma_unit reports the DMA transfer size:
  - 2 (4 bytes) when cfg_ext is 1.
  - 0 (1 byte) when cfg_ext is 0 and the width is 8 bits or less.
  - 1 (2 bytes) for any other width.
- R6: A bus write while the transmit queue holds DEPTH entries is dropped, and tx_ovf is set. tx_ovf stays set until reset.
- R7: A bus read while the receive queue is empty returns zero in bus_rdata, and rx_unf is set. rx_unf stays set until reset.
- R8: A receive sample arriving while the receive queue holds DEPTH entries is discarded, and rx_ovr is set until reset. This holds even if a bus read removes an entry on the same cycle.
- R9: A push and a pop on the same queue in the same cycle leave the level unchanged. A bus read on an empty receive queue returns zero, while a sample arriving on that same cycle is still stored.
- R10: The transmit queue needs service when tx_level <= cfg_tx_thresh. The receive queue needs service when rx_level > cfg_rx_thresh. irq is cfg_irq_en AND (either need), as seen by the state machine one clock after the levels.
- R11: dma_req is cfg_dma_en AND (either need), with the same one-clock delay as irq.
- R12: After reset:
  - both levels are 0;
  - all three sticky flags are 0;
  - bus_rdata is 0;
  - tx_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Bus write strobe; pushes to the transmit queue |
| bus_rd | input | 1 | Bus read strobe; pops the receive queue |
| bus_wdata | input | 32 | Bus write data |
| bus_rdata | output | 32 | Bus read data, registered |
| cfg_ext | input | 1 | Extended sample-size bit |
| cfg_size | input | 4 | Sample-size code |
| cfg_tx_thresh | input | 5 | Transmit service threshold |
| cfg_rx_thresh | input | 5 | Receive service threshold |
| cfg_irq_en | input | 1 | Interrupt request enable |
| cfg_dma_en | input | 1 | DMA request enable |
| tx_valid | output | 1 | Transmit sample available to the serializer |
| tx_data | output | 32 | Head transmit sample, masked to the width |
| tx_take | input | 1 | Serializer consumes the head transmit sample |
| rx_valid | input | 1 | Serializer delivers a receive sample |
| rx_data | input | 32 | Receive sample from the serializer |
| irq | output | 1 | Interrupt request |
| dma_req | output | 1 | DMA service request |
| dma_unit | output | 2 | DMA transfer size: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes |
| tx_level | output | 5 | Transmit queue occupancy |
| rx_level | output | 5 | Receive queue occupancy |
| tx_ovf | output | 1 | Sticky transmit overflow |
| rx_unf | output | 1 | Sticky receive underflow |
| rx_ovr | output | 1 | Sticky receive overrun |

## Verification
The bus pop and the serializer push of the receive queue can land on the same clock edge. So can the bus push and the serializer pop of the transmit queue. The bench drives both strobes together on an empty receive queue, then on a one-entry queue, then on a full queue. In each case it judges the result from the returned word (zero, the old head, or the first stored sample) and from the level that follows (1, 1, and 15 respectively). A sweep over all 32 size codes checks the transmit mask, the receive mask and the DMA unit against values computed arithmetically in the bench.

// File: rtl/ssb_pkg.sv
package ssb_pkg;

    localparam int WORD_W = 32;

    typedef enum logic [1:0] {
        SVC_IDLE = 2'd0,
        SVC_TX   = 2'd1,
        SVC_RX   = 2'd2,
        SVC_BOTH = 2'd3
    } svc_state_t;

    typedef enum logic [1:0] {
        UNIT_BYTE = 2'd0,
        UNIT_HALF = 2'd1,
        UNIT_WORD = 2'd2
    } dma_unit_t;

    // Sample width in bits: {ext, code} + 1, never below 4.
    function automatic logic [5:0] sample_bits(input logic ext, input logic [3:0] code);
        logic [5:0] b;
        b = {1'b0, ext, code} + 6'd1;
        if (b < 6'd4) begin
            b = 6'd4;
        end
        return b;
    endfunction

    // Mask with the low 'bits' positions set.
    function automatic logic [WORD_W-1:0] sample_mask(input logic [5:0] bits);
        logic [WORD_W:0] m;
        m = ({{WORD_W{1'b0}}, 1'b1} << bits) - {{WORD_W{1'b0}}, 1'b1};
        return m[WORD_W-1:0];
    endfunction

endpackage

// File: rtl/ssb_size_cfg.sv
module ssb_size_cfg
    import ssb_pkg::*;
(
    input  logic              cfg_ext,
    input  logic [3:0]        cfg_size,
    output logic [WORD_W-1:0] mask,
    output logic [1:0]        unit
);

    logic [5:0] bits;

    always_comb begin
        bits = sample_bits(cfg_ext, cfg_size);
        mask = sample_mask(bits);
        if (cfg_ext) begin
            unit = UNIT_WORD;
        end else if (bits <= 6'd8) begin
            unit = UNIT_BYTE;
        end else begin
            unit = UNIT_HALF;
        end
    end

endmodule

// File: rtl/ssb_fifo.sv
module ssb_fifo #(
    parameter  int W     = 32,
    parameter  int DEPTH = 16,
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic [W-1:0]  din,
    output logic [W-1:0]  head,
    output logic [LW-1:0] level,
    output logic          full,
    output logic          empty
);

    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp;
    logic [AW-1:0] rp;
    logic [LW-1:0] cnt;
    logic          do_push;
    logic          do_pop;

    assign full    = (cnt == LW'(DEPTH));
    assign empty   = (cnt == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rp];
    assign level   = cnt;

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wp] <= din;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) begin
                wp <= (wp == LAST) ? '0 : wp + AW'(1);
            end
            if (do_pop) begin
                rp <= (rp == LAST) ? '0 : rp + AW'(1);
            end
            unique case ({do_push, do_pop})
                2'b10:   cnt <= cnt + LW'(1);
                2'b01:   cnt <= cnt - LW'(1);
                default: cnt <= cnt;
            endcase
        end
    end

endmodule

// File: rtl/ssb_svc_fsm.sv
module ssb_svc_fsm
    import ssb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tx_need,
    input  logic rx_need,
    input  logic irq_en,
    input  logic dma_en,
    output logic irq,
    output logic dma_req
);

    svc_state_t state;
    svc_state_t state_nx;

    // Transitions go_idle / go_tx / go_rx / go_both.
    always_comb begin
        unique case ({tx_need, rx_need})
            2'b00: state_nx = SVC_IDLE;
            2'b10: state_nx = SVC_TX;
            2'b01: state_nx = SVC_RX;
            2'b11: state_nx = SVC_BOTH;
            default: state_nx = SVC_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SVC_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        irq     = 1'b0;
        dma_req = 1'b0;
        unique case (state)
            SVC_IDLE: begin
                irq     = 1'b0;
                dma_req = 1'b0;
            end
            SVC_TX, SVC_RX, SVC_BOTH: begin
                irq     = irq_en;
                dma_req = dma_en;
            end
            default: begin
                irq     = 1'b0;
                dma_req = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/serial_sample_buffer.sv
module serial_sample_buffer
    import ssb_pkg::*;
#(
    parameter  int DEPTH = 16,
    localparam int LW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    input  logic              cfg_ext,
    input  logic [3:0]        cfg_size,
    input  logic [LW-1:0]     cfg_tx_thresh,
    input  logic [LW-1:0]     cfg_rx_thresh,
    input  logic              cfg_irq_en,
    input  logic              cfg_dma_en,
    output logic              tx_valid,
    output logic [WORD_W-1:0] tx_data,
    input  logic              tx_take,
    input  logic              rx_valid,
    input  logic [WORD_W-1:0] rx_data,
    output logic              irq,
    output logic              dma_req,
    output logic [1:0]        dma_unit,
    output logic [LW-1:0]     tx_level,
    output logic [LW-1:0]     rx_level,
    output logic              tx_ovf,
    output logic              rx_unf,
    output logic              rx_ovr
);

    logic [WORD_W-1:0] mask;
    logic [WORD_W-1:0] tx_head;
    logic [WORD_W-1:0] rx_head;
    logic              tx_full;
    logic              tx_empty;
    logic              rx_full;
    logic              rx_empty;
    logic              tx_need;
    logic              rx_need;

    ssb_size_cfg u_size (
        .cfg_ext  (cfg_ext),
        .cfg_size (cfg_size),
        .mask     (mask),
        .unit     (dma_unit)
    );

    ssb_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_txq (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (bus_wr),
        .pop   (tx_take),
        .din   (bus_wdata),
        .head  (tx_head),
        .level (tx_level),
        .full  (tx_full),
        .empty (tx_empty)
    );

    ssb_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_rxq (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (rx_valid),
        .pop   (bus_rd),
        .din   (rx_data & mask),
        .head  (rx_head),
        .level (rx_level),
        .full  (rx_full),
        .empty (rx_empty)
    );

    assign tx_valid = !tx_empty;
    assign tx_data  = tx_head & mask;
    assign tx_need  = (tx_level <= cfg_tx_thresh);
    assign rx_need  = (rx_level > cfg_rx_thresh);

    ssb_svc_fsm u_svc (
        .clk     (clk),
        .rst_n   (rst_n),
        .tx_need (tx_need),
        .rx_need (rx_need),
        .irq_en  (cfg_irq_en),
        .dma_en  (cfg_dma_en),
        .irq     (irq),
        .dma_req (dma_req)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
            tx_ovf    <= 1'b0;
            rx_unf    <= 1'b0;
            rx_ovr    <= 1'b0;
        end else begin
            if (bus_rd) begin
                bus_rdata <= rx_empty ? '0 : rx_head;
            end
            if (bus_wr && tx_full) begin
                tx_ovf <= 1'b1;
            end
            if (bus_rd && rx_empty) begin
                rx_unf <= 1'b1;
            end
            if (rx_valid && rx_full) begin
                rx_ovr <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/ssb_checker.sv
module ssb_checker
    import ssb_pkg::*;
#(
    parameter  int DEPTH = 16,
    localparam int LW    = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [WORD_W-1:0] bus_rdata,
    input logic              cfg_ext,
    input logic [3:0]        cfg_size,
    input logic              cfg_irq_en,
    input logic              cfg_dma_en,
    input logic [WORD_W-1:0] tx_data,
    input logic              tx_take,
    input logic              rx_valid,
    input logic              irq,
    input logic              dma_req,
    input logic [1:0]        dma_unit,
    input logic [LW-1:0]     tx_level,
    input logic [LW-1:0]     rx_level,
    input logic              tx_ovf,
    input logic              rx_unf,
    input logic              rx_ovr
);

    localparam logic [LW-1:0] FULL = LW'(DEPTH);

    assert_level_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_level <= FULL) && (rx_level <= FULL));

    assert_tx_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_data & ~sample_mask(sample_bits(cfg_ext, cfg_size))) == '0);

    assert_dma_unit_ext_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_ext |-> (dma_unit == 2'd2));

    assert_tx_full_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (tx_level == FULL) && !tx_take) |=> ((tx_level == FULL) && tx_ovf));

    assert_ovf_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ovf |=> tx_ovf);

    assert_empty_read_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && (rx_level == '0)) |=> ((bus_rdata == '0) && rx_unf));

    assert_rx_full_discard_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && (rx_level == FULL) && !bus_rd) |=> ((rx_level == FULL) && rx_ovr));

    assert_sticky_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ovr |=> rx_ovr) and (rx_unf |=> rx_unf));

    assert_irq_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_irq_en |-> !irq);

    assert_dma_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_dma_en |-> !dma_req);

endmodule

bind serial_sample_buffer ssb_checker #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_rdata  (bus_rdata),
    .cfg_ext    (cfg_ext),
    .cfg_size   (cfg_size),
    .cfg_irq_en (cfg_irq_en),
    .cfg_dma_en (cfg_dma_en),
    .tx_data    (tx_data),
    .tx_take    (tx_take),
    .rx_valid   (rx_valid),
    .irq        (irq),
    .dma_req    (dma_req),
    .dma_unit   (dma_unit),
    .tx_level   (tx_level),
    .rx_level   (rx_level),
    .tx_ovf     (tx_ovf),
    .rx_unf     (rx_unf),
    .rx_ovr     (rx_ovr)
);

// File: tb/serial_sample_buffer_bench.sv
module serial_sample_buffer_bench;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        cfg_ext = 1'b1;
    logic [3:0]  cfg_size = 4'hF;
    logic [4:0]  cfg_tx_thresh = '0;
    logic [4:0]  cfg_rx_thresh = '0;
    logic        cfg_irq_en = 1'b0;
    logic        cfg_dma_en = 1'b0;
    logic        tx_valid;
    logic [31:0] tx_data;
    logic        tx_take = 1'b0;
    logic        rx_valid = 1'b0;
    logic [31:0] rx_data = '0;
    logic        irq;
    logic        dma_req;
    logic [1:0]  dma_unit;
    logic [4:0]  tx_level;
    logic [4:0]  rx_level;
    logic        tx_ovf;
    logic        rx_unf;
    logic        rx_ovr;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    serial_sample_buffer #(.DEPTH(DEPTH)) u_serial_sample_buffer (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic bus_write(input logic [31:0] v);
        bus_wr = 1'b1;
        bus_wdata = v;
        step();
        bus_wr = 1'b0;
    endtask

    task automatic bus_read();
        bus_rd = 1'b1;
        step();
        bus_rd = 1'b0;
    endtask

    task automatic rx_push(input logic [31:0] v);
        rx_valid = 1'b1;
        rx_data = v;
        step();
        rx_valid = 1'b0;
    endtask

    task automatic tx_pop();
        tx_take = 1'b1;
        step();
        tx_take = 1'b0;
    endtask

    function automatic logic [31:0] exp_mask(input int code);
        int b;
        b = code + 1;
        if (b < 4) b = 4;
        if (b == 32) return 32'hFFFF_FFFF;
        return (32'd1 << b) - 32'd1;
    endfunction

    function automatic logic [31:0] exp_unit(input int code);
        int b;
        b = code + 1;
        if (b < 4) b = 4;
        if (code >= 16) return 32'd2;
        if (b <= 8) return 32'd0;
        return 32'd1;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] p;
        repeat (3) step();
        rst_n = 1'b1;
        step();

        // R12 reset state
        chk("R12 tx_level", {27'd0, tx_level}, 32'd0);
        chk("R12 rx_level", {27'd0, rx_level}, 32'd0);
        chk("R12 flags", {29'd0, tx_ovf, rx_unf, rx_ovr}, 32'd0);
        chk("R12 rdata", bus_rdata, 32'd0);
        chk("R12 tx_valid", {31'd0, tx_valid}, 32'd0);

        // R3 R4 R5 sweep over all size codes
        for (int i = 0; i < 32; i++) begin
            cfg_ext = i[4];
            cfg_size = i[3:0];
            p = 32'hDEAD_BEEF ^ (i * 32'h0101_0107);
            bus_write(p);
            chk("R1 tx_valid after write", {31'd0, tx_valid}, 32'd1);
            chk("R3 tx_data mask", tx_data, p & exp_mask(i));
            chk("R5 dma_unit", {30'd0, dma_unit}, exp_unit(i));
            tx_pop();
            rx_push(p);
            bus_read();
            chk("R4 rx stored mask", bus_rdata, p & exp_mask(i));
        end

        // R4 width taken at arrival
        cfg_ext = 1'b0;
        cfg_size = 4'd7;
        rx_push(32'hFFFF_FFFF);
        cfg_ext = 1'b1;
        cfg_size = 4'hF;
        bus_read();
        chk("R4 width at arrival", bus_rdata, 32'h0000_00FF);

        // R1 R6 transmit fill, overflow, order
        for (int k = 0; k < DEPTH; k++) bus_write(32'h100 + k);
        chk("R1 tx full level", {27'd0, tx_level}, 32'd16);
        chk("R6 tx_ovf before", {31'd0, tx_ovf}, 32'd0);
        bus_write(32'hBAD0_BAD0);
        chk("R6 level after drop", {27'd0, tx_level}, 32'd16);
        chk("R6 tx_ovf set", {31'd0, tx_ovf}, 32'd1);
        for (int k = 0; k < DEPTH; k++) begin
            chk("R1 tx order", tx_data, 32'h100 + k);
            tx_pop();
        end
        chk("R1 tx drained", {31'd0, tx_valid}, 32'd0);
        chk("R6 tx_ovf sticky", {31'd0, tx_ovf}, 32'd1);

        // R7 underflow
        chk("R7 rx_unf before", {31'd0, rx_unf}, 32'd0);
        bus_read();
        chk("R7 empty read zero", bus_rdata, 32'd0);
        chk("R7 rx_unf set", {31'd0, rx_unf}, 32'd1);

        // R8 R2 overrun and order
        for (int k = 0; k < 17; k++) rx_push(32'h200 + k);
        chk("R8 rx level full", {27'd0, rx_level}, 32'd16);
        chk("R8 rx_ovr set", {31'd0, rx_ovr}, 32'd1);
        for (int k = 0; k < DEPTH; k++) begin
            bus_read();
            chk("R2 rx order", bus_rdata, 32'h200 + k);
        end
        chk("R2 rx drained", {27'd0, rx_level}, 32'd0);

        // R9 simultaneous push and pop
        rx_valid = 1'b1; rx_data = 32'h3A; bus_rd = 1'b1;
        step();
        rx_valid = 1'b0; bus_rd = 1'b0;
        chk("R9 empty read with push rdata", bus_rdata, 32'd0);
        chk("R9 empty read with push level", {27'd0, rx_level}, 32'd1);
        rx_valid = 1'b1; rx_data = 32'h3B; bus_rd = 1'b1;
        step();
        rx_valid = 1'b0; bus_rd = 1'b0;
        chk("R9 rx push+pop rdata", bus_rdata, 32'h3A);
        chk("R9 rx push+pop level", {27'd0, rx_level}, 32'd1);
        bus_read();
        chk("R9 rx follow-up", bus_rdata, 32'h3B);
        bus_write(32'h4A);
        bus_wr = 1'b1; bus_wdata = 32'h4B; tx_take = 1'b1;
        step();
        bus_wr = 1'b0; tx_take = 1'b0;
        chk("R9 tx push+pop level", {27'd0, tx_level}, 32'd1);
        chk("R9 tx push+pop head", tx_data, 32'h4B);
        tx_pop();

        // R8 full queue with simultaneous read
        for (int k = 0; k < DEPTH; k++) rx_push(32'h500 + k);
        rx_valid = 1'b1; rx_data = 32'h5FF; bus_rd = 1'b1;
        step();
        rx_valid = 1'b0; bus_rd = 1'b0;
        chk("R8 full read+push rdata", bus_rdata, 32'h500);
        chk("R8 full read+push level", {27'd0, rx_level}, 32'd15);
        for (int k = 0; k < 15; k++) bus_read();
        chk("R8 discarded sample absent", bus_rdata, 32'h50F);
        chk("R8 drained", {27'd0, rx_level}, 32'd0);

        // R10 receive threshold through irq
        cfg_irq_en = 1'b1; cfg_dma_en = 1'b0;
        cfg_tx_thresh = 5'd0; cfg_rx_thresh = 5'd3;
        bus_write(32'h1);
        for (int n = 0; n <= 5; n++) begin
            if (n > 0) rx_push(32'h600 + n);
            step();
            chk("R10 irq vs rx level", {31'd0, irq}, (n > 3) ? 32'd1 : 32'd0);
            chk("R11 dma_req gated off", {31'd0, dma_req}, 32'd0);
        end
        cfg_irq_en = 1'b0; cfg_dma_en = 1'b1;
        step();
        chk("R11 dma_req on rx", {31'd0, dma_req}, 32'd1);
        chk("R10 irq gated off", {31'd0, irq}, 32'd0);
        for (int k = 0; k < 5; k++) bus_read();

        // R11 transmit threshold through dma_req
        cfg_rx_thresh = 5'd16; cfg_tx_thresh = 5'd5;
        tx_pop();
        for (int n = 0; n <= DEPTH; n++) begin
            if (n > 0) bus_write(32'h700 + n);
            step();
            chk("R11 dma_req vs tx level", {31'd0, dma_req}, (n <= 5) ? 32'd1 : 32'd0);
        end
        cfg_irq_en = 1'b1;
        step();
        chk("R10 irq idle when full tx", {31'd0, irq}, 32'd0);
        for (int k = 0; k < DEPTH; k++) tx_pop();
        step();
        chk("R10 irq after tx drain", {31'd0, irq}, 32'd1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule